// File: doc/BRIEF.md
# Local Bus Cycle Timeout Monitor

This block watches every transfer cycle on the on-board local bus. If a cycle has not been acknowledged within a fixed span (128 µs by default), the block ends the cycle with a bus error. The targets include on-board I/O, mezzanine I/O, dual-ported memory and backplane-bound accesses. A clock prescaler turns the system clock into microsecond ticks, and a span counter counts those ticks.

For a backplane access, the monitor times only the wait from the bus request until external bus ownership is granted. The grant pulse restarts the count. From then on the backplane cycle is left to a separate monitor. An enable bit from the board control register turns the monitor on and off. A sticky timeout flag tells software that a bus error came from this timer and not from some other source. Software clears the flag with an explicit strobe.

Top module: `lbus_timeout_mon`

## Requirements
- R1: After synchronous reset, `berr` and `tmo_flag` are both low.
- R2: With `mon_en` high and no acknowledge or grant, `berr` is still low after the (N-1)th consecutive rising edge at which `cyc_act` is sampled high, and is high after the Nth, where N = `CLKS_PER_US` × `TIMEOUT_US`.
- R3: Once `berr` is high it stays high while `cyc_act` and `mon_en` stay high. It goes low at the first edge where `cyc_act` is sampled low.
- R4: An edge at which `xfer_ack` is sampled high produces no bus error, even if it is the Nth edge. It also clears the count, so a strobe that stays active afterwards needs N further edges to time out.
- R5: An edge at which `cyc_act` is sampled low clears the count. A cycle that starts afterwards needs a full N edges to time out.
- R6: An edge at which `ext_own_gnt` is sampled high clears the count, and the grant takes priority over a timeout on that same edge. The backplane wait is then timed afresh from zero.
- R7: `tmo_flag` goes high on the same edge as `berr` rises. It stays high after `berr` is released.
- R8: An edge at which `stat_clr` is sampled high, with no timeout on that edge, leaves `tmo_flag` low.
- R9: When a timeout and `stat_clr` fall on the same edge, `tmo_flag` ends high.
- R10: While `mon_en` is low, `berr` never rises and the count is held at zero. When `mon_en` is raised during an active cycle, timing starts from zero, so a full N edges pass before `berr`.
- R11: An edge at which `mon_en` is sampled low forces `berr` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_act | input | 1 | High while a local bus transfer cycle is in progress |
| xfer_ack | input | 1 | Normal transfer acknowledge from the addressed target |
| ext_own_gnt | input | 1 | One-clock pulse when external bus ownership is gained |
| mon_en | input | 1 | Monitor enable bit from the control register |
| stat_clr | input | 1 | Strobe that clears the timeout status flag |
| berr | output | 1 | Bus error that terminates the current cycle |
| tmo_flag | output | 1 | Sticky flag: a bus error came from this timer |

## Verification
The exact timeout cycle is tested with a small prescaler and a short span. `berr` is sampled one edge before and at the boundary, which separates a correct count from an off-by-one or a skipped prescaler reset. The span is interrupted in three ways: an acknowledge on the final edge, a grant pulse two edges before the limit, and a one-edge strobe drop. Each of these must restart a full-length count, which shows that each source really clears the count and does not just pause it. The enable is held low across three spans and then raised during a cycle, which shows the count was held at zero. A status clear that lands on the same edge as a timeout shows which of the two wins.

// File: rtl/lbto_pkg.sv
// Package: lbto_pkg
// Shared helpers and types for the local bus timeout monitor.
// Assumes: every count parameter it is given is a positive integer.
package lbto_pkg;

    // Width of a counter that must hold 0 .. n-1 (at least one bit)
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Output bundle of the error/status control stage
    typedef struct packed {
        logic berr;
        logic flag;
    } lbto_out_t;

endpackage

// File: rtl/lbto_prescale.sv
// Module: lbto_prescale
// Divides the system clock into one tick per microsecond of bus time.
// Counts only when not cleared. A clear restarts the phase at zero, so the
// first tick comes exactly DIV counting clocks after the clear is released.
// Assumes: DIV >= 1; with DIV == 1 a tick is issued on every counting clock.
module lbto_prescale #(
    parameter int unsigned DIV = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    import lbto_pkg::*;

    localparam int unsigned PW = cnt_w(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;
    logic          at_last;

    // Decode the final phase of a microsecond
    assign at_last = (phase_q == LAST);
    assign tick    = !clr && at_last;

    // Advance the phase while counting; clear on restart or at wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clr || at_last) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PW'(1);
        end
    end

endmodule

// File: rtl/lbto_span_cnt.sv
// Module: lbto_span_cnt
// Counts microsecond ticks within one monitored cycle. Raises hit on the tick
// that completes the span of SPAN ticks.
// Assumes: SPAN >= 1; tick is only high when clr is low.
module lbto_span_cnt #(
    parameter int unsigned SPAN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic hit
);
    import lbto_pkg::*;

    localparam int unsigned SW = cnt_w(SPAN);
    localparam logic [SW-1:0] LAST = SW'(SPAN - 1);

    logic [SW-1:0] us_q;

    // Span ends on the tick that finds the counter at its last value
    assign hit = tick && (us_q == LAST);

    // Accumulate ticks; restart on clear or when the span completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            us_q <= '0;
        end else if (clr || hit) begin
            us_q <= '0;
        end else if (tick) begin
            us_q <= us_q + SW'(1);
        end
    end

endmodule

// File: rtl/lbto_err_ctl.sv
// Module: lbto_err_ctl
// Holds the bus error output and the sticky timeout status flag.
// The bus error is set by a span hit and held until the strobe drops or the
// monitor is disabled. The flag is set by a hit and cleared by software; a hit
// wins over a clear on the same edge.
// Assumes: hit is only high while the monitor is enabled and a cycle is active.
module lbto_err_ctl (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit,
    input  logic                cyc_act,
    input  logic                mon_en,
    input  logic                stat_clr,
    output lbto_pkg::lbto_out_t st
);
    logic berr_q;
    logic flag_q;

    // Bus error: release on strobe drop or disable, otherwise latch a hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            berr_q <= 1'b0;
        end else if (!mon_en || !cyc_act) begin
            berr_q <= 1'b0;
        end else if (hit) begin
            berr_q <= 1'b1;
        end
    end

    // Status flag: a hit sets it and beats a same-edge software clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (stat_clr) begin
            flag_q <= 1'b0;
        end
    end

    // Bundle the registered outputs
    always_comb begin
        st.berr = berr_q;
        st.flag = flag_q;
    end

endmodule

// File: rtl/lbus_timeout_mon.sv
// Module: lbus_timeout_mon
// Top of the local bus cycle timeout monitor. Times each active cycle in
// microseconds and raises a bus error after TIMEOUT_US with no acknowledge.
// A grant of external bus ownership restarts the count, so on backplane
// accesses only the arbitration wait is timed.
// Assumes: ext_own_gnt is a single-clock pulse; all inputs are synchronous.
module lbus_timeout_mon #(
    parameter int unsigned CLKS_PER_US = 33,
    parameter int unsigned TIMEOUT_US  = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_act,
    input  logic xfer_ack,
    input  logic ext_own_gnt,
    input  logic mon_en,
    input  logic stat_clr,
    output logic berr,
    output logic tmo_flag
);
    import lbto_pkg::*;

    logic      run;
    logic      cnt_clr;
    logic      us_tick;
    logic      span_hit;
    lbto_out_t ctl_st;

    // Count only while enabled, in a cycle, and not already in error
    assign run     = mon_en && cyc_act && !ctl_st.berr;
    // Any normal end, ownership grant or idle condition restarts the count
    assign cnt_clr = !run || xfer_ack || ext_own_gnt;

    lbto_prescale #(
        .DIV (CLKS_PER_US)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .tick  (us_tick)
    );

    lbto_span_cnt #(
        .SPAN (TIMEOUT_US)
    ) u_span (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .tick  (us_tick),
        .hit   (span_hit)
    );

    lbto_err_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (span_hit),
        .cyc_act  (cyc_act),
        .mon_en   (mon_en),
        .stat_clr (stat_clr),
        .st       (ctl_st)
    );

    assign berr     = ctl_st.berr;
    assign tmo_flag = ctl_st.flag;

endmodule

// File: rtl/lbus_timeout_mon_chk.sv
// Module: lbus_timeout_mon_chk
// Property checker for lbus_timeout_mon, attached by bind below. It keeps its
// own run-length counter so the timeout window is checked without deep $past.
module lbus_timeout_mon_chk #(
    parameter int unsigned CLKS_PER_US = 33,
    parameter int unsigned TIMEOUT_US  = 128
) (
    input logic clk,
    input logic rst_n,
    input logic cyc_act,
    input logic xfer_ack,
    input logic ext_own_gnt,
    input logic mon_en,
    input logic stat_clr,
    input logic berr,
    input logic tmo_flag
);
    localparam int unsigned LIMIT = CLKS_PER_US * TIMEOUT_US;

    int unsigned run_len;

    // Count consecutive edges that the monitor must time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= 0;
        end else if (mon_en && cyc_act && !berr && !xfer_ack && !ext_own_gnt) begin
            run_len <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    // R2: the error rises exactly when the run reaches the limit
    a_r2_rise_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(berr) |-> (run_len == LIMIT));

    // R2: no run reaches the limit without an error
    a_r2_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        !berr |-> (run_len < LIMIT));

    // R3: held while strobe and enable stay high
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (berr && cyc_act && mon_en) |=> berr);

    // R3: released after strobe drop
    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_act |=> !berr);

    // R4: acknowledge prevents an error
    a_r4_ack_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack && !berr) |=> !berr);

    // R6: grant prevents an error on its edge
    a_r6_gnt_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_own_gnt && !berr) |=> !berr);

    // R7: flag set together with the error
    a_r7_flag_with_err: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(berr) |-> tmo_flag);

    // R7: flag sticky without a clear
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && !stat_clr) |=> tmo_flag);

    // R8: clear takes effect unless a new error rises
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> (!tmo_flag || $rose(berr)));

    // R11: disable forces the error low
    a_r11_dis_release: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> !berr);

endmodule

bind lbus_timeout_mon lbus_timeout_mon_chk #(
    .CLKS_PER_US (CLKS_PER_US),
    .TIMEOUT_US  (TIMEOUT_US)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_act     (cyc_act),
    .xfer_ack    (xfer_ack),
    .ext_own_gnt (ext_own_gnt),
    .mon_en      (mon_en),
    .stat_clr    (stat_clr),
    .berr        (berr),
    .tmo_flag    (tmo_flag)
);

// File: tb/lbus_timeout_mon_test.sv
// Bench: lbus_timeout_mon_test
// Directed scenarios, one task each, with a small prescaler and span so the
// timeout boundary can be sampled exactly. Inputs are driven and outputs are
// sampled on the falling edge.
module lbus_timeout_mon_test;

    localparam int unsigned CPU = 3;
    localparam int unsigned TUS = 4;
    localparam int          N   = CPU * TUS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_act = 1'b0;
    logic xfer_ack = 1'b0;
    logic ext_own_gnt = 1'b0;
    logic mon_en = 1'b0;
    logic stat_clr = 1'b0;
    logic berr;
    logic tmo_flag;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lbus_timeout_mon #(
        .CLKS_PER_US (CPU),
        .TIMEOUT_US  (TUS)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_act     (cyc_act),
        .xfer_ack    (xfer_ack),
        .ext_own_gnt (ext_own_gnt),
        .mon_en      (mon_en),
        .stat_clr    (stat_clr),
        .berr        (berr),
        .tmo_flag    (tmo_flag)
    );

    // Pass n rising edges and land on the following falling edge
    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Return to idle and clear the status flag
    task automatic idle();
        cyc_act = 1'b0; xfer_ack = 1'b0; ext_own_gnt = 1'b0;
        stat_clr = 1'b1; step(1);
        stat_clr = 1'b0; step(1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(2);
        chk("R1", "berr after reset", berr, 1'b0);
        chk("R1", "flag after reset", tmo_flag, 1'b0);
        rst_n = 1'b1; step(1);
    endtask

    // R2 boundary, R3 hold/release, R7 flag sticky
    task automatic t_timeout_exact();
        idle(); mon_en = 1'b1;
        cyc_act = 1'b1; step(N - 1);
        chk("R2", "berr one edge before limit", berr, 1'b0);
        chk("R7", "flag before limit", tmo_flag, 1'b0);
        step(1);
        chk("R2", "berr at limit", berr, 1'b1);
        chk("R7", "flag with berr", tmo_flag, 1'b1);
        step(5);
        chk("R3", "berr held", berr, 1'b1);
        cyc_act = 1'b0; step(1);
        chk("R3", "berr released", berr, 1'b0);
        step(3);
        chk("R7", "flag sticky", tmo_flag, 1'b1);
    endtask

    task automatic t_ack_last_edge();
        idle(); mon_en = 1'b1;
        cyc_act = 1'b1; step(N - 1);
        xfer_ack = 1'b1; step(1);
        chk("R4", "no berr with ack on limit edge", berr, 1'b0);
        xfer_ack = 1'b0; step(N - 1);
        chk("R4", "restarted count below limit", berr, 1'b0);
        step(1);
        chk("R4", "restarted count at limit", berr, 1'b1);
        cyc_act = 1'b0; step(1);
    endtask

    task automatic t_strobe_drop();
        idle(); mon_en = 1'b1;
        cyc_act = 1'b1; step(N - 1);
        cyc_act = 1'b0; step(1);
        cyc_act = 1'b1; step(N - 1);
        chk("R5", "new cycle below limit", berr, 1'b0);
        step(1);
        chk("R5", "new cycle at limit", berr, 1'b1);
        cyc_act = 1'b0; step(1);
    endtask

    task automatic t_grant_restart();
        idle(); mon_en = 1'b1;
        cyc_act = 1'b1; step(N - 2);
        ext_own_gnt = 1'b1; step(1);
        chk("R6", "no berr on grant edge", berr, 1'b0);
        ext_own_gnt = 1'b0; step(N - 1);
        chk("R6", "after grant below limit", berr, 1'b0);
        step(1);
        chk("R6", "after grant at limit", berr, 1'b1);
        cyc_act = 1'b0; step(1);
        // grant on the limit edge wins over the timeout
        cyc_act = 1'b1; step(N - 1);
        ext_own_gnt = 1'b1; step(1);
        chk("R6", "grant on limit edge", berr, 1'b0);
        ext_own_gnt = 1'b0; cyc_act = 1'b0; step(1);
    endtask

    task automatic t_status_clear();
        idle(); mon_en = 1'b1;
        cyc_act = 1'b1; step(N);
        cyc_act = 1'b0; step(1);
        chk("R7", "flag set before clear", tmo_flag, 1'b1);
        stat_clr = 1'b1; step(1);
        chk("R8", "flag cleared", tmo_flag, 1'b0);
        stat_clr = 1'b0; step(1);
    endtask

    task automatic t_clear_vs_hit();
        idle(); mon_en = 1'b1;
        cyc_act = 1'b1; step(N);
        cyc_act = 1'b0; step(1);
        cyc_act = 1'b1; step(N - 1);
        stat_clr = 1'b1; step(1);
        chk("R9", "berr on contested edge", berr, 1'b1);
        chk("R9", "hit beats clear", tmo_flag, 1'b1);
        stat_clr = 1'b0; cyc_act = 1'b0; step(1);
    endtask

    task automatic t_disabled();
        idle(); mon_en = 1'b0;
        cyc_act = 1'b1; step(3 * N);
        chk("R10", "no berr while disabled", berr, 1'b0);
        chk("R10", "no flag while disabled", tmo_flag, 1'b0);
        mon_en = 1'b1; step(N - 1);
        chk("R10", "enable mid-cycle below limit", berr, 1'b0);
        step(1);
        chk("R10", "enable mid-cycle at limit", berr, 1'b1);
        mon_en = 1'b0; step(1);
        chk("R11", "disable releases berr", berr, 1'b0);
        cyc_act = 1'b0; step(1);
    endtask

    initial begin
        step(1);
        t_reset();
        t_timeout_exact();
        t_ack_last_edge();
        t_strobe_drop();
        t_grant_restart();
        t_status_clear();
        t_clear_vs_hit();
        t_disabled();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule